// File: doc/BRIEF.md
# DMA Shared-Memory Write Guard

This block sits in the write path between two DMA engines, one per processing subsystem, and a bank of global shared memory blocks. Every DMA write is screened in the same cycle it is presented. The screen has two stages. The first asks whether the issuing subsystem owns the target block. The second asks whether the owner has locked that block against its own DMA. A write that passes reaches the memory as a write enable. A write that fails is dropped.

Each subsystem keeps its own record of its failed writes. That record holds two violation kinds (non-owner and owner-locked), a sticky overflow marker, and the address of the first fault. Each subsystem also has its own interrupt line: subsystem 1's error interrupt cannot be masked, while subsystem 2's interrupt depends on an enable bit. A debug qualifier that travels with each DMA write disables all screening for that write.

Software uses a small word-addressed register port to set ownership, lock bits and the interrupt enable, to read the records, and to clear flags by writing 1s to them.

Top module: `dmawp_guard`

## Requirements
- R1: The target block of a DMA write is given by the top log2(NUM_BLK) address bits. Bit i of the owner register (offset 0) selects the owner of block i: 0 means subsystem 1 and 1 means subsystem 2. A non-debug write is forwarded only when the issuing subsystem owns the target block.
- R2: A non-debug write from the owning subsystem is blocked when bit i of the lock register (offset 2'd1, register offset 1) is set for the target block.
- R3: A blocked write from a non-owner sets bit 0 of that subsystem's flag register (offset 3 for subsystem 1, offset 5 for subsystem 2). This holds whatever the lock bit is. A blocked write from the owner sets bit 1 of the same register. These flags are visible on the cycle after the write.
- R4: A blocked write keeps the matching memory write enable low in the same cycle it is presented. A forwarded write drives the enable high in that cycle.
- R5: A violation that occurs while bits 0 and 1 of the subsystem's flag register are both clear stores the faulting address. The address is stored in the subsystem's address register (offset 4 or 6) and can be read on the next cycle.
- R6: A violation that occurs while bit 0 or bit 1 is already set leaves the stored address unchanged and sets overflow bit 2. The overflow bit stays set until it is cleared.
- R7: Writing the flag register clears every bit that is written as 1. If a new violation arrives in the same cycle as the clear, the new violation's flag is set anyway.
- R8: Subsystem 1's error interrupt is high for exactly one cycle, the cycle after each violation by that subsystem, with no enable.
- R9: Subsystem 2's violation interrupt pulses in the same way, but only when bit 0 of the enable register (offset 2) is 1.
- R10: A write with its debug qualifier high is always forwarded. It sets no flag, stores no address and raises no interrupt.
- R11: The two subsystems are judged and recorded independently, including when both violate in the same cycle.
- R12: After reset, every block is owned by subsystem 1. Lock bits, the enable bit, all flags and both stored addresses are zero. Offset 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| s1_dma_wr | input | 1 | Subsystem 1 DMA write request |
| s1_dma_addr | input | ADDR_W | Subsystem 1 DMA write address |
| s1_dma_dbg | input | 1 | Subsystem 1 debug-access qualifier |
| s1_mem_we | output | 1 | Screened write enable for subsystem 1 |
| s2_dma_wr | input | 1 | Subsystem 2 DMA write request |
| s2_dma_addr | input | ADDR_W | Subsystem 2 DMA write address |
| s2_dma_dbg | input | 1 | Subsystem 2 debug-access qualifier |
| s2_mem_we | output | 1 | Screened write enable for subsystem 2 |
| s1_err_irq | output | 1 | Subsystem 1 DMA error interrupt pulse |
| s2_av_irq | output | 1 | Subsystem 2 violation interrupt pulse |

## Verification
A corrupted ownership or lock bit shows up in the same cycle: the next write to that block produces the wrong memory enable. A wrong flag or overflow state shows up one cycle later, through the interrupt pulse and the flag register read. It also affects the following violations, because the flags decide whether an address is stored or overflow is set instead. The bench therefore compares both enables, both interrupts and the read data against a behavioural model on every clock. The read offset is swept on every clock so that stored state is exposed continuously rather than only at the end.

// File: rtl/dmawp_pkg.sv
package dmawp_pkg;

   // Register word offsets
   typedef enum logic [2:0] {
      RA_OWNER = 3'd0,
      RA_LOCK  = 3'd1,
      RA_IRQEN = 3'd2,
      RA_S1FLG = 3'd3,
      RA_S1ADR = 3'd4,
      RA_S2FLG = 3'd5,
      RA_S2ADR = 3'd6
   } reg_addr_e;

   // Classification of one DMA write
   typedef struct packed {
      logic own_lock;
      logic non_own;
   } viol_kind_t;

   // Per-subsystem flag register, bit 0 = non_own
   typedef struct packed {
      logic ovf;
      logic own_lock;
      logic non_own;
   } viol_flags_t;

endpackage

// File: rtl/dmawp_cfg_regs.sv
module dmawp_cfg_regs
   import dmawp_pkg::*;
#(
   parameter int NUM_BLK = 8,
   parameter int DATA_W  = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [NUM_BLK-1:0] owner_map,
   output logic [NUM_BLK-1:0] lock_map,
   output logic               s2_irq_en
);

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_BLK];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_map <= '0;
         lock_map  <= '0;
         s2_irq_en <= 1'b0;
      end else if (reg_wr) begin
         case (reg_addr_e'(reg_addr))
            RA_OWNER: owner_map <= reg_wdata[NUM_BLK-1:0];
            RA_LOCK:  lock_map  <= reg_wdata[NUM_BLK-1:0];
            RA_IRQEN: s2_irq_en <= reg_wdata[0];
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/dmawp_judge.sv
module dmawp_judge
   import dmawp_pkg::*;
#(
   parameter int NUM_BLK = 8,
   parameter int IDX_W   = $clog2(NUM_BLK),
   parameter int SUB_ID  = 0
)(
   input  logic               wr,
   input  logic               dbg,
   input  logic [IDX_W-1:0]   blk,
   input  logic [NUM_BLK-1:0] owner_map,
   input  logic [NUM_BLK-1:0] lock_map,
   output logic               mem_we,
   output viol_kind_t         kind
);

   localparam logic OWN_CODE = (SUB_ID != 0);

   logic screened;
   logic owner_hit;

   assign screened      = wr & ~dbg;
   assign owner_hit     = (owner_map[blk] == OWN_CODE);
   assign kind.non_own  = screened & ~owner_hit;
   assign kind.own_lock = screened & owner_hit & lock_map[blk];
   assign mem_we        = wr & ~(kind.non_own | kind.own_lock);

endmodule

// File: rtl/dmawp_viol_log.sv
module dmawp_viol_log
   import dmawp_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter bit IRQ_GATED = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  viol_kind_t        kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic              clr_wr,
   input  logic [2:0]        clr_mask,
   input  logic              irq_en,
   output viol_flags_t       flags_q,
   output logic [ADDR_W-1:0] cap_addr,
   output logic              irq
);

   logic       hit;
   logic       any_set;
   logic       irq_gate;
   logic [2:0] clr;

   assign hit      = kind.non_own | kind.own_lock;
   assign any_set  = flags_q.non_own | flags_q.own_lock;
   assign irq_gate = IRQ_GATED ? irq_en : 1'b1;
   assign clr      = clr_wr ? clr_mask : 3'b000;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q  <= '0;
         cap_addr <= '0;
         irq      <= 1'b0;
      end else begin
         flags_q.non_own  <= (flags_q.non_own  & ~clr[0]) | kind.non_own;
         flags_q.own_lock <= (flags_q.own_lock & ~clr[1]) | kind.own_lock;
         flags_q.ovf      <= (flags_q.ovf      & ~clr[2]) | (hit & any_set);
         if (hit && !any_set)
            cap_addr <= addr;
         irq <= hit & irq_gate;
      end
   end

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(hit));

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q.ovf && !clr[2]) |=> flags_q.ovf);

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_set |=> $stable(cap_addr));

endmodule

// File: rtl/dmawp_guard.sv
module dmawp_guard
   import dmawp_pkg::*;
#(
   parameter int NUM_BLK = 8,
   parameter int ADDR_W  = 13,
   parameter int DATA_W  = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              s1_dma_wr,
   input  logic [ADDR_W-1:0] s1_dma_addr,
   input  logic              s1_dma_dbg,
   output logic              s1_mem_we,
   input  logic              s2_dma_wr,
   input  logic [ADDR_W-1:0] s2_dma_addr,
   input  logic              s2_dma_dbg,
   output logic              s2_mem_we,
   output logic              s1_err_irq,
   output logic              s2_av_irq
);

   localparam int IDX_W = $clog2(NUM_BLK);

   if (NUM_BLK < 2 || (NUM_BLK & (NUM_BLK - 1)) != 0) begin : g_bad_blk
      $error("NUM_BLK must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the block index width");
   end
   if (DATA_W <= NUM_BLK || DATA_W < ADDR_W) begin : g_bad_data
      $error("DATA_W too narrow for the register map");
   end

   logic [NUM_BLK-1:0] owner_map;
   logic [NUM_BLK-1:0] lock_map;
   logic               s2_irq_en;

   logic [1:0]        wr_v, dbg_v, we_v, irq_v;
   logic [ADDR_W-1:0] addr_v [2];
   logic [ADDR_W-1:0] cap_v  [2];
   viol_kind_t        kind_v [2];
   viol_flags_t       flg_v  [2];

   assign wr_v      = {s2_dma_wr,  s1_dma_wr};
   assign dbg_v     = {s2_dma_dbg, s1_dma_dbg};
   assign addr_v[0] = s1_dma_addr;
   assign addr_v[1] = s2_dma_addr;
   assign s1_mem_we  = we_v[0];
   assign s2_mem_we  = we_v[1];
   assign s1_err_irq = irq_v[0];
   assign s2_av_irq  = irq_v[1];

   dmawp_cfg_regs #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .owner_map (owner_map),
      .lock_map  (lock_map),
      .s2_irq_en (s2_irq_en)
   );

   for (genvar s = 0; s < 2; s++) begin : g_sub
      localparam logic [2:0] FLG_OFS = (s == 0) ? RA_S1FLG : RA_S2FLG;

      logic clr_hit;
      assign clr_hit = reg_wr && (reg_addr == FLG_OFS);

      dmawp_judge #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W), .SUB_ID(s)) u_judge (
         .wr        (wr_v[s]),
         .dbg       (dbg_v[s]),
         .blk       (addr_v[s][ADDR_W-1 -: IDX_W]),
         .owner_map (owner_map),
         .lock_map  (lock_map),
         .mem_we    (we_v[s]),
         .kind      (kind_v[s])
      );

      dmawp_viol_log #(.ADDR_W(ADDR_W), .IRQ_GATED(s != 0)) u_log (
         .clk      (clk),
         .rst_n    (rst_n),
         .kind     (kind_v[s]),
         .addr     (addr_v[s]),
         .clr_wr   (clr_hit),
         .clr_mask (reg_wdata[2:0]),
         .irq_en   (s2_irq_en),
         .flags_q  (flg_v[s]),
         .cap_addr (cap_v[s]),
         .irq      (irq_v[s])
      );

      // R10
      dbg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_v[s] && dbg_v[s]) |-> we_v[s]);

      // R4
      we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         we_v[s] |-> wr_v[s]);

      // R3
      kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({kind_v[s].non_own, kind_v[s].own_lock}));

      // R7
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit && reg_wdata[0] && !kind_v[s].non_own) |=> !flg_v[s].non_own);
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr_e'(reg_addr))
         RA_OWNER: reg_rdata[NUM_BLK-1:0] = owner_map;
         RA_LOCK:  reg_rdata[NUM_BLK-1:0] = lock_map;
         RA_IRQEN: reg_rdata[0]           = s2_irq_en;
         RA_S1FLG: reg_rdata[2:0]         = flg_v[0];
         RA_S1ADR: reg_rdata[ADDR_W-1:0]  = cap_v[0];
         RA_S2FLG: reg_rdata[2:0]         = flg_v[1];
         RA_S2ADR: reg_rdata[ADDR_W-1:0]  = cap_v[1];
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: tb/tb_dmawp_guard.sv
module tb_dmawp_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        s1_dma_wr = 1'b0, s1_dma_dbg = 1'b0;
   logic [12:0] s1_dma_addr = '0;
   logic        s2_dma_wr = 1'b0, s2_dma_dbg = 1'b0;
   logic [12:0] s2_dma_addr = '0;
   logic        s1_mem_we, s2_mem_we, s1_err_irq, s2_av_irq;

   always #2 clk = ~clk;

   dmawp_guard dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .s1_dma_wr(s1_dma_wr), .s1_dma_addr(s1_dma_addr), .s1_dma_dbg(s1_dma_dbg), .s1_mem_we(s1_mem_we),
      .s2_dma_wr(s2_dma_wr), .s2_dma_addr(s2_dma_addr), .s2_dma_dbg(s2_dma_dbg), .s2_mem_we(s2_mem_we),
      .s1_err_irq(s1_err_irq), .s2_av_irq(s2_av_irq)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // Reference model state
   logic [7:0]  m_owner = '0, m_lock = '0;
   logic        m_en = 1'b0;
   logic [2:0]  m_flg [2] = '{3'b0, 3'b0};
   logic [12:0] m_adr [2] = '{13'b0, 13'b0};
   logic        m_irq [2] = '{1'b0, 1'b0};

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void judge(int s, logic wr, logic [12:0] a, logic dbg,
                                 output logic we, output logic no, output logic ol);
      int blk = int'(a[12:10]);
      no = 1'b0; ol = 1'b0;
      if (wr && !dbg) begin
         if (m_owner[blk] != (s != 0)) no = 1'b1;
         else if (m_lock[blk]) ol = 1'b1;
      end
      we = wr && !no && !ol;
   endfunction

   function automatic logic [31:0] exp_rd(logic [2:0] ra);
      case (ra)
         3'd0: return {24'b0, m_owner};
         3'd1: return {24'b0, m_lock};
         3'd2: return {31'b0, m_en};
         3'd3: return {29'b0, m_flg[0]};
         3'd4: return {19'b0, m_adr[0]};
         3'd5: return {29'b0, m_flg[1]};
         3'd6: return {19'b0, m_adr[1]};
         default: return 32'b0;
      endcase
   endfunction

   // Compare in the middle of the low phase, then advance the model at the edge
   task automatic cycle();
      logic we [2], no [2], ol [2];
      logic [2:0]  nf [2];
      logic [12:0] na [2];
      logic        ni [2];
      logic [7:0]  n_owner, n_lock;
      logic        n_en;
      #1;
      judge(0, s1_dma_wr, s1_dma_addr, s1_dma_dbg, we[0], no[0], ol[0]);
      judge(1, s2_dma_wr, s2_dma_addr, s2_dma_dbg, we[1], no[1], ol[1]);
      chk("R1 R2 R4 R10 R11 s1_mem_we", {31'b0, s1_mem_we}, {31'b0, we[0]});
      chk("R1 R2 R4 R10 R11 s2_mem_we", {31'b0, s2_mem_we}, {31'b0, we[1]});
      chk("R8 s1_err_irq", {31'b0, s1_err_irq}, {31'b0, m_irq[0]});
      chk("R9 s2_av_irq", {31'b0, s2_av_irq}, {31'b0, m_irq[1]});
      chk("R3 R5 R6 R7 R12 reg_rdata", reg_rdata, exp_rd(reg_addr));
      for (int s = 0; s < 2; s++) begin
         logic [2:0] clr;
         logic anyf;
         logic [12:0] a;
         a = (s == 0) ? s1_dma_addr : s2_dma_addr;
         clr = (reg_wr && reg_addr == ((s == 0) ? 3'd3 : 3'd5)) ? reg_wdata[2:0] : 3'b0;
         anyf = m_flg[s][0] | m_flg[s][1];
         nf[s] = m_flg[s] & ~clr;
         na[s] = m_adr[s];
         if (no[s]) nf[s][0] = 1'b1;
         if (ol[s]) nf[s][1] = 1'b1;
         if (no[s] || ol[s]) begin
            if (!anyf) na[s] = a;
            else nf[s][2] = 1'b1;
         end
         ni[s] = (no[s] || ol[s]) && (s == 0 || m_en);
      end
      n_owner = m_owner; n_lock = m_lock; n_en = m_en;
      if (reg_wr) begin
         if (reg_addr == 3'd0) n_owner = reg_wdata[7:0];
         if (reg_addr == 3'd1) n_lock  = reg_wdata[7:0];
         if (reg_addr == 3'd2) n_en    = reg_wdata[0];
      end
      @(posedge clk);
      m_owner = n_owner; m_lock = n_lock; m_en = n_en;
      for (int s = 0; s < 2; s++) begin
         m_flg[s] = nf[s]; m_adr[s] = na[s]; m_irq[s] = ni[s];
      end
      @(negedge clk);
   endtask

   task automatic step(logic rw, logic [2:0] ra, logic [31:0] wd,
                       logic w1, logic [12:0] a1, logic d1,
                       logic w2, logic [12:0] a2, logic d2);
      reg_wr = rw; reg_addr = ra; reg_wdata = wd;
      s1_dma_wr = w1; s1_dma_addr = a1; s1_dma_dbg = d1;
      s2_dma_wr = w2; s2_dma_addr = a2; s2_dma_dbg = d2;
      cycle();
   endtask

   task automatic rd(logic [2:0] ra);
      step(1'b0, ra, 32'b0, 1'b0, 13'h0, 1'b0, 1'b0, 13'h0, 1'b0);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12: reset contents of every offset
      for (int r = 0; r < 8; r++) rd(3'(r));
      // R1: subsystem 1 owns block 2 after reset
      step(0, 3'd3, 0, 1, 13'h0812, 0, 0, 0, 0);
      // R3 R5: subsystem 2 non-owner write, address stored
      step(0, 3'd5, 0, 0, 0, 0, 1, 13'h0834, 0);
      rd(3'd5); rd(3'd6);
      // hand block 2 to subsystem 2
      step(1, 3'd0, 32'h04, 0, 0, 0, 0, 0, 0);
      step(0, 3'd3, 0, 1, 13'h0900, 0, 1, 13'h0901, 0);
      rd(3'd4);
      // R2 R9: lock block 2, enable off -> no interrupt
      step(1, 3'd1, 32'h04, 0, 0, 0, 0, 0, 0);
      step(1, 3'd5, 32'h7, 0, 0, 0, 0, 0, 0);
      step(0, 3'd5, 0, 0, 0, 0, 1, 13'h0A55, 0);
      rd(3'd5); rd(3'd6);
      // R9 R6: enable on, second violation overflows
      step(1, 3'd2, 32'h1, 0, 0, 0, 0, 0, 0);
      step(0, 3'd6, 0, 0, 0, 0, 1, 13'h0BEE, 0);
      rd(3'd5); rd(3'd6);
      // R7: clear with simultaneous new violation
      step(1, 3'd5, 32'h7, 0, 0, 0, 1, 13'h0800, 0);
      rd(3'd5); rd(3'd6);
      step(1, 3'd5, 32'h7, 0, 0, 0, 0, 0, 0);
      rd(3'd5);
      // R10: debug bypass on blocked targets
      step(0, 3'd3, 0, 1, 13'h0804, 1, 1, 13'h0805, 1);
      rd(3'd3); rd(3'd5);
      // R11: both violate together
      step(1, 3'd1, 32'h05, 0, 0, 0, 0, 0, 0);
      step(0, 3'd3, 0, 1, 13'h0010, 0, 1, 13'h0820, 0);
      rd(3'd3); rd(3'd4); rd(3'd5); rd(3'd6);
      step(1, 3'd3, 32'h7, 1, 13'h1C00, 0, 0, 0, 0);
      rd(3'd3); rd(3'd4);
      // Mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         logic rw;
         rw = ($urandom % 8) == 0;
         step(rw, 3'($urandom), $urandom,
              1'($urandom), 13'($urandom), ($urandom % 8) == 0,
              1'($urandom), 13'($urandom), ($urandom % 8) == 0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule